// File: doc/BRIEF.md
# Three-Bus Register-Transfer Datapath

This block is the execution datapath of a non-pipelined processor. Its two operand buses (A and B) feed an ALU, and the ALU result drives the third bus (C). A general register file, a program counter, an instruction register and a memory port hang off these buses. The memory port has an address register and a data register. The block has no sequencer of its own. Each clock, an external controller presents one control step. That step enables the sources for the A and B buses, picks an ALU function, and names the registers that capture the C bus at the coming edge. An instruction therefore takes as many clocks as the controller spends steps on it.

The controller may ask for an impossible step: two sources on one operand bus, or a read and a write command at once. The block flags such a step in the same cycle and lets nothing change state. A memory transaction runs under a small state machine. Its states are MEM_IDLE, MEM_READ and MEM_WRITE:

- A legal read command moves it from MEM_IDLE to MEM_READ.
- A legal write command moves it from MEM_IDLE to MEM_WRITE.
- In either busy state, the acknowledge from memory returns it to MEM_IDLE.
- On the edge that ends a read, the returned word is captured into the data register.

Top module: `tribus_datapath`

## Requirements
- R1: After reset, the program counter, instruction register, memory address register, memory data register and every general register hold zero, and `mem_req` and `mem_busy` are low.
- R2: Sources and buses:
  - The A bus carries register-file port A (`sel_a`) when `a_from_rf` is set, or the memory data register when `a_from_mdr` is set.
  - The B bus carries register-file port B (`sel_b`), the program counter (`b_from_pc`), or instruction-register bits 15:0 sign-extended to 32 bits (`b_from_imm`).
  - A bus with no enabled source reads zero.
- R3: `alu_op` picks the C bus value combinationally: 0 A+B, 1 A−B, 2 A AND B, 3 A OR B, 4 A XOR B, 5 signed A<B giving 1 or 0, 6 A, 7 B.
- R4: With `ld_rf` set in a legal step, the C bus is written into general register `sel_c` at the clock edge. A three-register add completes in one step.
- R5: General register 0 always reads zero, and writes to it are discarded.
- R6: `ld_pc` and `ld_ir` load the program counter and instruction register from the C bus at the edge. With the memory port idle, `ld_mar` and `ld_mdr` do the same for the address and data registers.
- R7: `step_illegal` is high in the same cycle when both A sources are enabled, when more than one B source is enabled, or when `mem_rd` and `mem_wr` are both set. It is low otherwise.
- R8: An illegal step changes no register and starts no memory transaction.
- R9: In MEM_IDLE, a legal `mem_rd` raises `mem_req` with `mem_we` low from the next cycle, addressed by the address register. When `mem_done` is seen, `mem_rdata` enters the data register at that edge and `mem_req` drops the next cycle.
- R10: In MEM_IDLE, a legal `mem_wr` raises `mem_req` and `mem_we` from the next cycle, with `mem_wdata` equal to the data register, until `mem_done` is seen.
- R11: While `mem_busy` is high, new memory commands and C-bus loads of the address and data registers have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel_a | input | 5 | Register index for read port A |
| sel_b | input | 5 | Register index for read port B |
| sel_c | input | 5 | Register index written from the C bus |
| a_from_rf | input | 1 | Read port A drives the A bus |
| a_from_mdr | input | 1 | Memory data register drives the A bus |
| b_from_rf | input | 1 | Read port B drives the B bus |
| b_from_pc | input | 1 | Program counter drives the B bus |
| b_from_imm | input | 1 | Sign-extended immediate drives the B bus |
| alu_op | input | 3 | ALU function code |
| ld_rf | input | 1 | Write C bus into register `sel_c` |
| ld_pc | input | 1 | Load program counter from C bus |
| ld_ir | input | 1 | Load instruction register from C bus |
| ld_mar | input | 1 | Load memory address register from C bus |
| ld_mdr | input | 1 | Load memory data register from C bus |
| mem_rd | input | 1 | Start a memory read |
| mem_wr | input | 1 | Start a memory write |
| mem_done | input | 1 | Memory acknowledge for the pending transaction |
| mem_rdata | input | 32 | Read data from memory |
| mem_addr | output | 32 | Memory address (address register) |
| mem_wdata | output | 32 | Memory write data (data register) |
| mem_req | output | 1 | Transaction pending |
| mem_we | output | 1 | Pending transaction is a write |
| mem_busy | output | 1 | Memory port not idle |
| bus_a | output | 32 | A bus value |
| bus_b | output | 32 | B bus value |
| bus_c | output | 32 | C bus (ALU result) value |
| pc_out | output | 32 | Program counter |
| ir_out | output | 32 | Instruction register |
| step_illegal | output | 1 | Current control step is illegal |

## Verification
The bench builds the block at its defaults: 32-bit words, 32 general registers and a 16-bit immediate field. At these values the signed compare sees a real sign bit. The immediate crosses its bit-15 sign boundary. Both ends of the register index range are reached: register 0 for the zero rule and register 31 for the top entry. Every value enters through a memory read handshake and leaves through the C bus, so the tests also exercise the memory state machine's MEM_READ path. The tests also cover the no-effect rules during a pending write.

// File: rtl/tribus_pkg.sv
package tribus_pkg;

    typedef enum logic [2:0] {
        ALU_ADD    = 3'd0,
        ALU_SUB    = 3'd1,
        ALU_AND    = 3'd2,
        ALU_OR     = 3'd3,
        ALU_XOR    = 3'd4,
        ALU_SLT    = 3'd5,
        ALU_PASS_A = 3'd6,
        ALU_PASS_B = 3'd7
    } alu_op_e;

    typedef enum logic [1:0] {
        MEM_IDLE  = 2'd0,
        MEM_READ  = 2'd1,
        MEM_WRITE = 2'd2
    } mem_state_e;

endpackage

// File: rtl/tribus_alu.sv
module tribus_alu
    import tribus_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] opnd_a,
    input  logic [W-1:0] opnd_b,
    input  logic [2:0]   op_code,
    output logic [W-1:0] result
);

    alu_op_e op;
    logic    less;

    assign op   = alu_op_e'(op_code);
    assign less = $signed(opnd_a) < $signed(opnd_b);

    always_comb begin
        unique case (op)
            ALU_ADD:    result = opnd_a + opnd_b;
            ALU_SUB:    result = opnd_a - opnd_b;
            ALU_AND:    result = opnd_a & opnd_b;
            ALU_OR:     result = opnd_a | opnd_b;
            ALU_XOR:    result = opnd_a ^ opnd_b;
            ALU_SLT:    result = {{(W-1){1'b0}}, less};
            ALU_PASS_A: result = opnd_a;
            ALU_PASS_B: result = opnd_b;
        endcase
    end

endmodule

// File: rtl/tribus_regfile.sv
module tribus_regfile #(
    parameter int W = 32,
    parameter int N = 32,
    localparam int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [IW-1:0] rsel_a,
    input  logic [IW-1:0] rsel_b,
    input  logic [IW-1:0] wsel,
    input  logic          wen,
    input  logic [W-1:0]  wdata,
    output logic [W-1:0]  rdata_a,
    output logic [W-1:0]  rdata_b
);

    logic [W-1:0] entry_q [N];

    for (genvar g = 0; g < N; g++) begin : g_ent
        if (g == 0) begin : g_zero
            assign entry_q[g] = '0;
        end else begin : g_reg
            logic [W-1:0] q;
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    q <= '0;
                end else if (wen && (wsel == IW'(g))) begin
                    q <= wdata;
                end
            end
            assign entry_q[g] = q;
        end
    end

    assign rdata_a = entry_q[rsel_a];
    assign rdata_b = entry_q[rsel_b];

endmodule

// File: rtl/tribus_memif.sv
module tribus_memif
    import tribus_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step_ok,
    input  logic         cmd_rd,
    input  logic         cmd_wr,
    input  logic         ld_mar,
    input  logic         ld_mdr,
    input  logic [W-1:0] c_bus,
    input  logic         done,
    input  logic [W-1:0] rdata,
    output logic [W-1:0] mar_q,
    output logic [W-1:0] mdr_q,
    output logic         req,
    output logic         we,
    output logic         busy
);

    mem_state_e state, state_nxt;
    logic       idle;

    assign idle = (state == MEM_IDLE);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= MEM_IDLE;
        end else begin
            state <= state_nxt;
        end
    end

    // transitions
    always_comb begin
        state_nxt = state;
        unique case (state)
            MEM_IDLE: begin
                if (step_ok && cmd_rd) begin
                    state_nxt = MEM_READ;
                end else if (step_ok && cmd_wr) begin
                    state_nxt = MEM_WRITE;
                end
            end
            MEM_READ, MEM_WRITE: begin
                if (done) begin
                    state_nxt = MEM_IDLE;
                end
            end
            default: state_nxt = MEM_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        req  = 1'b0;
        we   = 1'b0;
        busy = 1'b0;
        unique case (state)
            MEM_IDLE: begin
            end
            MEM_READ: begin
                req  = 1'b1;
                busy = 1'b1;
            end
            MEM_WRITE: begin
                req  = 1'b1;
                we   = 1'b1;
                busy = 1'b1;
            end
            default: begin
            end
        endcase
    end

    // address and data registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mar_q <= '0;
            mdr_q <= '0;
        end else begin
            if (idle && step_ok && ld_mar) begin
                mar_q <= c_bus;
            end
            if ((state == MEM_READ) && done) begin
                mdr_q <= rdata;
            end else if (idle && step_ok && ld_mdr) begin
                mdr_q <= c_bus;
            end
        end
    end

endmodule

// File: rtl/tribus_datapath.sv
module tribus_datapath #(
    parameter int DATA_W = 32,
    parameter int NREGS  = 32,
    parameter int IMM_W  = 16,
    localparam int RIDX_W = $clog2(NREGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [RIDX_W-1:0] sel_a,
    input  logic [RIDX_W-1:0] sel_b,
    input  logic [RIDX_W-1:0] sel_c,
    input  logic              a_from_rf,
    input  logic              a_from_mdr,
    input  logic              b_from_rf,
    input  logic              b_from_pc,
    input  logic              b_from_imm,
    input  logic [2:0]        alu_op,
    input  logic              ld_rf,
    input  logic              ld_pc,
    input  logic              ld_ir,
    input  logic              ld_mar,
    input  logic              ld_mdr,
    input  logic              mem_rd,
    input  logic              mem_wr,
    input  logic              mem_done,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [DATA_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic              mem_busy,
    output logic [DATA_W-1:0] bus_a,
    output logic [DATA_W-1:0] bus_b,
    output logic [DATA_W-1:0] bus_c,
    output logic [DATA_W-1:0] pc_out,
    output logic [DATA_W-1:0] ir_out
,
    output logic              step_illegal
);

    logic [DATA_W-1:0] rf_a, rf_b, mdr_q, imm_ext;
    logic [DATA_W-1:0] pc_q, ir_q;
    logic              step_ok;

    // contention check for the current control step
    always_comb begin
        step_illegal = 1'b0;
        if (a_from_rf && a_from_mdr) begin
            step_illegal = 1'b1;
        end
        if ((32'(b_from_rf) + 32'(b_from_pc) + 32'(b_from_imm)) > 32'd1) begin
            step_illegal = 1'b1;
        end
        if (mem_rd && mem_wr) begin
            step_illegal = 1'b1;
        end
    end

    assign step_ok = !step_illegal;

    assign imm_ext = {{(DATA_W-IMM_W){ir_q[IMM_W-1]}}, ir_q[IMM_W-1:0]};

    assign bus_a = ({DATA_W{a_from_rf}}  & rf_a)
                 | ({DATA_W{a_from_mdr}} & mdr_q);

    assign bus_b = ({DATA_W{b_from_rf}}  & rf_b)
                 | ({DATA_W{b_from_pc}}  & pc_q)
                 | ({DATA_W{b_from_imm}} & imm_ext);

    tribus_regfile #(
        .W (DATA_W),
        .N (NREGS)
    ) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .rsel_a  (sel_a),
        .rsel_b  (sel_b),
        .wsel    (sel_c),
        .wen     (ld_rf && step_ok),
        .wdata   (bus_c),
        .rdata_a (rf_a),
        .rdata_b (rf_b)
    );

    tribus_alu #(
        .W (DATA_W)
    ) u_alu (
        .opnd_a  (bus_a),
        .opnd_b  (bus_b),
        .op_code (alu_op),
        .result  (bus_c)
    );

    tribus_memif #(
        .W (DATA_W)
    ) u_mem (
        .clk     (clk),
        .rst_n   (rst_n),
        .step_ok (step_ok),
        .cmd_rd  (mem_rd),
        .cmd_wr  (mem_wr),
        .ld_mar  (ld_mar),
        .ld_mdr  (ld_mdr),
        .c_bus   (bus_c),
        .done    (mem_done),
        .rdata   (mem_rdata),
        .mar_q   (mem_addr),
        .mdr_q   (mdr_q),
        .req     (mem_req),
        .we      (mem_we),
        .busy    (mem_busy)
    );

    assign mem_wdata = mdr_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q <= '0;
            ir_q <= '0;
        end else if (step_ok) begin
            if (ld_pc) begin
                pc_q <= bus_c;
            end
            if (ld_ir) begin
                ir_q <= bus_c;
            end
        end
    end

    assign pc_out = pc_q;
    assign ir_out = ir_q;

endmodule

// File: rtl/tribus_checks.sv
module tribus_checks #(
    parameter int W  = 32,
    parameter int IW = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic          step_illegal,
    input logic [W-1:0]  pc_out,
    input logic [W-1:0]  ir_out,
    input logic          mem_req,
    input logic          mem_we,
    input logic          mem_done,
    input logic [W-1:0]  mem_addr,
    input logic [W-1:0]  mem_wdata,
    input logic [W-1:0]  mem_rdata,
    input logic          a_from_rf,
    input logic          a_from_mdr,
    input logic [IW-1:0] sel_a,
    input logic [W-1:0]  bus_a
);

    AST_ILLEGAL_KEEPS_PC: assert property (@(posedge clk) disable iff (!rst_n)
        step_illegal |=> $stable(pc_out)); // R8

    AST_ILLEGAL_KEEPS_IR: assert property (@(posedge clk) disable iff (!rst_n)
        step_illegal |=> $stable(ir_out)); // R8

    AST_ILLEGAL_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_req && step_illegal) |=> !mem_req); // R8

    AST_ZERO_REG_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (a_from_rf && !a_from_mdr && (sel_a == '0)) |-> (bus_a == '0)); // R5

    AST_READ_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we && mem_done) |=> (mem_wdata == $past(mem_rdata))); // R9

    AST_DONE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_done) |=> !mem_req); // R9

    AST_WRITE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && !mem_done) |=> (mem_we && $stable(mem_wdata))); // R10

    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_done) |=> $stable(mem_addr)); // R11

endmodule

bind tribus_datapath tribus_checks #(
    .W  (DATA_W),
    .IW (RIDX_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .step_illegal (step_illegal),
    .pc_out       (pc_out),
    .ir_out       (ir_out),
    .mem_req      (mem_req),
    .mem_we       (mem_we),
    .mem_done     (mem_done),
    .mem_addr     (mem_addr),
    .mem_wdata    (mem_wdata),
    .mem_rdata    (mem_rdata),
    .a_from_rf    (a_from_rf),
    .a_from_mdr   (a_from_mdr),
    .sel_a        (sel_a),
    .bus_a        (bus_a)
);

// File: tb/tribus_datapath_test.sv
module tribus_datapath_test;

    typedef struct packed {
        logic [4:0]  sa, sb, sc;
        logic        arf, amdr, brf, bpc, bimm;
        logic [2:0]  op;
        logic        lrf, lpc, lir, lmar, lmdr, rd, wr, done;
        logic [31:0] rdata;
    } ctl_t;

    typedef struct {
        logic        chk_c;
        logic [31:0] exp_c;
        logic        exp_ill;
        string       tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    ctl_t ctl = '0;
    exp_t sb_q[$];
    int   n_checks = 0;
    int   n_fail = 0;
    bit   finished = 1'b0;

    logic [31:0] mem_addr, mem_wdata, bus_a, bus_b, bus_c, pc_out, ir_out;
    logic        mem_req, mem_we, mem_busy, step_illegal;

    always #2 clk = ~clk;

    tribus_datapath uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .sel_a        (ctl.sa),
        .sel_b        (ctl.sb),
        .sel_c        (ctl.sc),
        .a_from_rf    (ctl.arf),
        .a_from_mdr   (ctl.amdr),
        .b_from_rf    (ctl.brf),
        .b_from_pc    (ctl.bpc),
        .b_from_imm   (ctl.bimm),
        .alu_op       (ctl.op),
        .ld_rf        (ctl.lrf),
        .ld_pc        (ctl.lpc),
        .ld_ir        (ctl.lir),
        .ld_mar       (ctl.lmar),
        .ld_mdr       (ctl.lmdr),
        .mem_rd       (ctl.rd),
        .mem_wr       (ctl.wr),
        .mem_done     (ctl.done),
        .mem_rdata    (ctl.rdata),
        .mem_addr     (mem_addr),
        .mem_wdata    (mem_wdata),
        .mem_req      (mem_req),
        .mem_we       (mem_we),
        .mem_busy     (mem_busy),
        .bus_a        (bus_a),
        .bus_b        (bus_b),
        .bus_c        (bus_c),
        .pc_out       (pc_out),
        .ir_out       (ir_out),
        .step_illegal (step_illegal)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // monitor: pops one expected item per driven step
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                check({e.tag, " illegal flag"}, 32'(step_illegal), 32'(e.exp_ill));
                if (e.chk_c) begin
                    check({e.tag, " C bus"}, bus_c, e.exp_c);
                end
            end
        end
    end

    // driver: one control step, expected result queued for the monitor
    task automatic run(ctl_t c, logic chk_c, logic [31:0] exp_c, logic exp_ill, string tag);
        exp_t e;
        @(negedge clk);
        ctl = c;
        e.chk_c = chk_c;
        e.exp_c = exp_c;
        e.exp_ill = exp_ill;
        e.tag = tag;
        sb_q.push_back(e);
        @(posedge clk);
        #1;
        ctl = '0;
    endtask

    task automatic load_reg(logic [4:0] r, logic [31:0] val);
        ctl_t c;
        c = '0;
        c.rd = 1'b1;
        run(c, 1'b0, '0, 1'b0, "R9 read start");
        check("R9 req raised", 32'(mem_req), 32'd1);
        check("R9 read not write", 32'(mem_we), 32'd0);
        c = '0;
        c.done = 1'b1;
        c.rdata = val;
        run(c, 1'b0, '0, 1'b0, "R9 read done");
        check("R9 req dropped", 32'(mem_req), 32'd0);
        c = '0;
        c.amdr = 1'b1;
        c.op = 3'd6;
        c.lrf = 1'b1;
        c.sc = r;
        run(c, 1'b1, val, 1'b0, "R9 captured data on A bus");
    endtask

    task automatic alu_rr(logic [4:0] ra, logic [4:0] rb, logic [2:0] op,
                          logic [31:0] exp, string tag);
        ctl_t c;
        c = '0;
        c.arf = 1'b1;
        c.sa = ra;
        c.brf = 1'b1;
        c.sb = rb;
        c.op = op;
        run(c, 1'b1, exp, 1'b0, tag);
    endtask

    initial begin
        #(4 * 20000);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        ctl_t c;
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;

        // R1 reset state
        check("R1 pc", pc_out, 32'd0);
        check("R1 ir", ir_out, 32'd0);
        check("R1 req", 32'(mem_req), 32'd0);
        check("R1 busy", 32'(mem_busy), 32'd0);
        check("R1 mar", mem_addr, 32'd0);
        check("R1 mdr", mem_wdata, 32'd0);
        alu_rr(5'd5, 5'd31, 3'd6, 32'd0, "R1 register 5 cleared");
        alu_rr(5'd1, 5'd31, 3'd7, 32'd0, "R1 register 31 cleared");

        // operands through the read handshake
        load_reg(5'd4, 32'd7);
        load_reg(5'd5, 32'd5);
        load_reg(5'd6, 32'hFFFF_FFF0);

        // R4 single-step add r3 = r4 + r5, then read back
        c = '0;
        c.arf = 1'b1; c.sa = 5'd4;
        c.brf = 1'b1; c.sb = 5'd5;
        c.op = 3'd0;
        c.lrf = 1'b1; c.sc = 5'd3;
        run(c, 1'b1, 32'd12, 1'b0, "R4 add step");
        alu_rr(5'd3, 5'd0, 3'd6, 32'd12, "R4 destination holds sum");
        c = '0;
        c.arf = 1'b1; c.sa = 5'd4; c.op = 3'd6;
        c.lrf = 1'b1; c.sc = 5'd31;
        run(c, 1'b1, 32'd7, 1'b0, "R4 write top register");
        alu_rr(5'd0, 5'd31, 3'd7, 32'd7, "R4 top register holds value");

        // R3 ALU function codes
        alu_rr(5'd4, 5'd5, 3'd1, 32'd2, "R3 sub");
        alu_rr(5'd5, 5'd4, 3'd1, 32'hFFFF_FFFE, "R3 sub negative");
        alu_rr(5'd4, 5'd5, 3'd2, 32'd5, "R3 and");
        alu_rr(5'd4, 5'd5, 3'd3, 32'd7, "R3 or");
        alu_rr(5'd4, 5'd5, 3'd4, 32'd2, "R3 xor");
        alu_rr(5'd4, 5'd5, 3'd5, 32'd0, "R3 slt false");
        alu_rr(5'd5, 5'd4, 3'd5, 32'd1, "R3 slt true");
        alu_rr(5'd6, 5'd4, 3'd5, 32'd1, "R3 slt signed");
        alu_rr(5'd4, 5'd5, 3'd7, 32'd5, "R3 pass B");

        // R5 register 0
        c = '0;
        c.arf = 1'b1; c.sa = 5'd4; c.op = 3'd6;
        c.lrf = 1'b1; c.sc = 5'd0;
        run(c, 1'b1, 32'd7, 1'b0, "R5 write to r0");
        alu_rr(5'd0, 5'd0, 3'd6, 32'd0, "R5 r0 on port A");
        alu_rr(5'd4, 5'd0, 3'd7, 32'd0, "R5 r0 on port B");

        // R2 empty buses
        c = '0;
        c.op = 3'd3;
        run(c, 1'b1, 32'd0, 1'b0, "R2 no sources");

        // R6 program counter, R2 PC on B bus
        c = '0;
        c.arf = 1'b1; c.sa = 5'd4; c.op = 3'd6; c.lpc = 1'b1;
        run(c, 1'b1, 32'd7, 1'b0, "R6 pc load");
        check("R6 pc value", pc_out, 32'd7);
        c = '0;
        c.bpc = 1'b1; c.op = 3'd7;
        run(c, 1'b1, 32'd7, 1'b0, "R2 pc on B bus");

        // R6 instruction register, R2 sign-extended immediate
        load_reg(5'd7, 32'h1234_8003);
        c = '0;
        c.arf = 1'b1; c.sa = 5'd7; c.op = 3'd6; c.lir = 1'b1;
        run(c, 1'b1, 32'h1234_8003, 1'b0, "R6 ir load");
        check("R6 ir value", ir_out, 32'h1234_8003);
        c = '0;
        c.bimm = 1'b1; c.op = 3'd7;
        run(c, 1'b1, 32'hFFFF_8003, 1'b0, "R2 immediate sign extension");

        // R7 / R8 illegal steps
        c = '0;
        c.arf = 1'b1; c.amdr = 1'b1; c.sa = 5'd5; c.op = 3'd6;
        c.lpc = 1'b1; c.lrf = 1'b1; c.sc = 5'd9;
        run(c, 1'b0, '0, 1'b1, "R7 A bus contention");
        check("R8 pc kept", pc_out, 32'd7);
        alu_rr(5'd9, 5'd0, 3'd6, 32'd0, "R8 register not written");
        c = '0;
        c.bpc = 1'b1; c.bimm = 1'b1; c.op = 3'd7; c.lir = 1'b1;
        run(c, 1'b0, '0, 1'b1, "R7 B bus contention");
        check("R8 ir kept", ir_out, 32'h1234_8003);
        c = '0;
        c.rd = 1'b1; c.wr = 1'b1;
        c.arf = 1'b1; c.sa = 5'd4; c.op = 3'd6; c.lmar = 1'b1;
        run(c, 1'b0, '0, 1'b1, "R7 read and write together");
        check("R8 no transaction", 32'(mem_req), 32'd0);
        check("R8 mar kept", mem_addr, 32'd0);

        // R10 write, R11 no effect while busy
        c = '0;
        c.arf = 1'b1; c.sa = 5'd4; c.op = 3'd6; c.lmar = 1'b1;
        run(c, 1'b1, 32'd7, 1'b0, "R6 mar load");
        c = '0;
        c.arf = 1'b1; c.sa = 5'd5; c.op = 3'd6; c.lmdr = 1'b1;
        run(c, 1'b1, 32'd5, 1'b0, "R6 mdr load");
        check("R6 mar value", mem_addr, 32'd7);
        check("R6 mdr value", mem_wdata, 32'd5);
        c = '0;
        c.wr = 1'b1;
        run(c, 1'b0, '0, 1'b0, "R10 write start");
        check("R10 req", 32'(mem_req), 32'd1);
        check("R10 we", 32'(mem_we), 32'd1);
        check("R10 busy", 32'(mem_busy), 32'd1);
        check("R10 address", mem_addr, 32'd7);
        check("R10 data", mem_wdata, 32'd5);
        c = '0;
        c.arf = 1'b1; c.sa = 5'd3; c.op = 3'd6;
        c.lmar = 1'b1; c.lmdr = 1'b1; c.rd = 1'b1;
        run(c, 1'b1, 32'd12, 1'b0, "R11 loads while busy");
        check("R11 address held", mem_addr, 32'd7);
        check("R11 data held", mem_wdata, 32'd5);
        check("R11 still writing", 32'(mem_we), 32'd1);
        c = '0;
        c.done = 1'b1;
        run(c, 1'b0, '0, 1'b0, "R10 write done");
        check("R10 req released", 32'(mem_req), 32'd0);
        check("R11 read command dropped", 32'(mem_busy), 32'd0);

        @(negedge clk);
        #2;
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule